// File: doc/BRIEF.md
# Multi-Register Block Transfer Sequencer

This block turns one load-multiple or store-multiple request into a train of single-word transfers. A request carries a 16-bit register mask, a base address, an addressing mode and a writeback flag. The block then walks the mask, issuing one beat per clock. Each beat gives a register index, a word address and the transfer direction. When the last beat has gone out, the block raises a one-cycle completion strobe and presents the base value the core should write back.

The addressing mode comes from one of two sources. It can be given directly as an up/down bit and a before/after bit. It can also be derived from stack semantics, in which case a full/empty bit and an ascending/descending bit are combined with the load/store direction. In every mode the beats go out in ascending register order with ascending addresses. A register with a lower index therefore always lands on a lower address, even when the block grows downward.

Top module: `blkxfer_seq`

## Requirements
- R1: With N set bits in the mask and aligned base B, the first beat address is B for increment-after, B+4 for increment-before, B-4N+4 for decrement-after and B-4N for decrement-before (up_i=1 means increment, pre_i=1 means before). Each following beat address is the previous one plus 4.
- R2: Beats appear on consecutive cycles, starting in the cycle after start is accepted. They carry exactly the set bits of the mask as register indices, in ascending order.
- R3: Bits [1:0] of base_i are ignored, and every beat address has bits [1:0] equal to zero.
- R4: While done_o is high, new_base_o equals B+4N (increment) or B-4N (decrement) when wb_i was set, and equals B when wb_i was clear.
- R5: With stack_i=1, up_i and pre_i are ignored. A load uses increment = desc_i and before = !full_i. A store uses increment = !desc_i and before = full_i. For example, full-descending gives increment-after for loads and decrement-before for stores.
- R6: An empty mask produces no beat, and done_o rises in the cycle after start.
- R7: done_o rises in the cycle after the last beat and stays high for exactly one cycle.
- R8: A start that arrives while beats are running or while done_o is high is ignored. It changes neither the running beat train nor the state that follows.
- R9: After reset, beat_vld_o and done_o are low.
- R10: beat_load_o carries the load_i value captured at start for every beat of the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start_i | input | 1 | request a new operation (taken only when idle) |
| reglist_i | input | 16 | register mask, bit k selects register k |
| base_i | input | 32 | base address |
| up_i | input | 1 | direct mode: 1 increment, 0 decrement |
| pre_i | input | 1 | direct mode: 1 step before, 0 step after |
| wb_i | input | 1 | write back the updated base |
| load_i | input | 1 | 1 load, 0 store |
| stack_i | input | 1 | derive mode from stack semantics |
| full_i | input | 1 | stack mode: 1 full, 0 empty |
| desc_i | input | 1 | stack mode: 1 descending, 0 ascending |
| beat_vld_o | output | 1 | a word transfer is presented this cycle |
| beat_reg_o | output | 4 | register index of this beat |
| beat_addr_o | output | 32 | word address of this beat |
| beat_load_o | output | 1 | direction of this beat |
| done_o | output | 1 | one-cycle completion strobe |
| new_base_o | output | 32 | base value to write back, valid with done_o |

## Verification
The hardest case to reach from the ports is a second start that arrives in the middle of a beat train or exactly on the done cycle. A careless design would either restart on that start or corrupt its remaining mask. The stimulus covers both. It raises start with a different mask and base one beat into a run, and it raises start again on the cycle done_o is seen. It then confirms that the beat train continues as predicted and that the cycle after done is quiet. Random masks, bases and mode bits are mixed with directed empty, single-bit and full masks under every direct and stack mode.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIN  = 2'd2
    } phase_e;
endpackage

// File: rtl/blkxfer_popcnt.sv
module blkxfer_popcnt #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);
    always_comb begin
        cnt_o = '0;
        for (int k = 0; k < W; k++) begin
            cnt_o = cnt_o + CW'(vec_i[k]);
        end
    end
endmodule

// File: rtl/blkxfer_lowbit.sv
module blkxfer_lowbit #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    always_comb begin
        idx_o = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (vec_i[k]) idx_o = IW'(k);
        end
        any_o = |vec_i;
    end
endmodule

// File: rtl/blkxfer_addrplan.sv
module blkxfer_addrplan #(
    parameter int AW = 32,
    parameter int CW = 5
) (
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          up_i,
    input  logic          pre_i,
    output logic [AW-1:0] aligned_o,
    output logic [AW-1:0] first_o,
    output logic [AW-1:0] wbval_o
);
    localparam logic [AW-1:0] WORD = AW'(4);
    logic [AW-1:0] span;

    always_comb begin
        aligned_o = {base_i[AW-1:2], 2'b00};
        span      = AW'(cnt_i) << 2;
        if (up_i) begin
            first_o = pre_i ? aligned_o + WORD : aligned_o;
            wbval_o = aligned_o + span;
        end else begin
            first_o = pre_i ? aligned_o - span : aligned_o - span + WORD;
            wbval_o = aligned_o - span;
        end
    end
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
    import blkxfer_pkg::*;
#(
    parameter int NREG = 16,
    parameter int AW   = 32,
    parameter int IW   = $clog2(NREG),
    parameter int CW   = $clog2(NREG + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [NREG-1:0] reglist_i,
    input  logic [AW-1:0]   base_i,
    input  logic            up_i,
    input  logic            pre_i,
    input  logic            wb_i,
    input  logic            load_i,
    input  logic            stack_i,
    input  logic            full_i,
    input  logic            desc_i,
    output logic            beat_vld_o,
    output logic [IW-1:0]   beat_reg_o,
    output logic [AW-1:0]   beat_addr_o,
    output logic            beat_load_o,
    output logic            done_o,
    output logic [AW-1:0]   new_base_o
);
    localparam logic [AW-1:0] STEP = AW'(4);

    typedef struct packed {
        phase_e          phase;
        logic [NREG-1:0] left;
        logic [AW-1:0]   addr;
        logic [AW-1:0]   nbase;
        logic            ld;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic [CW-1:0] cnt;
    logic [IW-1:0] cur_idx;
    logic          cur_any;
    logic          eff_up, eff_pre;
    logic [AW-1:0] aligned, first_addr, wbval;
    logic [NREG-1:0] left_next;

    blkxfer_popcnt #(.W(NREG), .CW(CW)) u_pop (
        .vec_i (reglist_i),
        .cnt_o (cnt)
    );

    blkxfer_lowbit #(.W(NREG), .IW(IW)) u_low (
        .vec_i (st_q.left),
        .idx_o (cur_idx),
        .any_o (cur_any)
    );

    always_comb begin
        if (stack_i) begin
            eff_up  = load_i ? desc_i : !desc_i;
            eff_pre = load_i ? !full_i : full_i;
        end else begin
            eff_up  = up_i;
            eff_pre = pre_i;
        end
    end

    blkxfer_addrplan #(.AW(AW), .CW(CW)) u_plan (
        .base_i    (base_i),
        .cnt_i     (cnt),
        .up_i      (eff_up),
        .pre_i     (eff_pre),
        .aligned_o (aligned),
        .first_o   (first_addr),
        .wbval_o   (wbval)
    );

    always_comb begin
        st_d      = st_q;
        left_next = st_q.left & ~(NREG'(1) << cur_idx);
        case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.left  = reglist_i;
                    st_d.addr  = first_addr;
                    st_d.nbase = wb_i ? wbval : aligned;
                    st_d.ld    = load_i;
                    st_d.phase = (reglist_i == '0) ? PH_FIN : PH_RUN;
                end
            end
            PH_RUN: begin
                st_d.left = left_next;
                st_d.addr = st_q.addr + STEP;
                if (left_next == '0) st_d.phase = PH_FIN;
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, left: '0, addr: '0, nbase: '0, ld: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_vld_o  = (st_q.phase == PH_RUN) && cur_any;
    assign beat_reg_o  = cur_idx;
    assign beat_addr_o = st_q.addr;
    assign beat_load_o = st_q.ld;
    assign done_o      = (st_q.phase == PH_FIN);
    assign new_base_o  = st_q.nbase;

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_beat_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld_o |-> (beat_addr_o[1:0] == 2'b00));

    assert_reg_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld_o |=> (!beat_vld_o || (beat_reg_o > $past(beat_reg_o))));

    assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld_o |=> (!beat_vld_o || (beat_addr_o == $past(beat_addr_o) + STEP)));

    assert_dir_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld_o |=> (!beat_vld_o || $stable(beat_load_o)));

    assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> (!beat_vld_o && !done_o));
endmodule

// File: tb/blkxfer_seq_tb_top.sv
module blkxfer_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] reglist_i = '0;
    logic [31:0] base_i = '0;
    logic        up_i = 1'b0, pre_i = 1'b0, wb_i = 1'b0, load_i = 1'b0;
    logic        stack_i = 1'b0, full_i = 1'b0, desc_i = 1'b0;
    logic        beat_vld_o;
    logic [3:0]  beat_reg_o;
    logic [31:0] beat_addr_o;
    logic        beat_load_o;
    logic        done_o;
    logic [31:0] new_base_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    blkxfer_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .reglist_i(reglist_i),
        .base_i(base_i), .up_i(up_i), .pre_i(pre_i), .wb_i(wb_i),
        .load_i(load_i), .stack_i(stack_i), .full_i(full_i), .desc_i(desc_i),
        .beat_vld_o(beat_vld_o), .beat_reg_o(beat_reg_o),
        .beat_addr_o(beat_addr_o), .beat_load_o(beat_load_o),
        .done_o(done_o), .new_base_o(new_base_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ones(input logic [15:0] m);
        int n = 0;
        for (int k = 0; k < 16; k++) n += int'(m[k]);
        return n;
    endfunction

    function automatic logic [31:0] first_of(input logic [31:0] b, input int n,
                                             input bit up, input bit pre);
        logic [31:0] a = {b[31:2], 2'b00};
        if (up) return pre ? a + 32'd4 : a;
        return pre ? a - 32'(4 * n) : a - 32'(4 * n) + 32'd4;
    endfunction

    // mid_restart: raise start one beat into the run; end_restart: raise start on done
    task automatic run_op(input logic [15:0] m, input logic [31:0] b, input bit up,
                          input bit pre, input bit wb, input bit ld, input bit stk,
                          input bit full, input bit desc, input bit mid_restart,
                          input bit end_restart);
        bit eu, ep, seen_done;
        int n, k, p;
        logic [31:0] a, nb;
        if (stk) begin
            eu = ld ? desc : !desc;   // R5
            ep = ld ? !full : full;
        end else begin
            eu = up; ep = pre;
        end
        n = ones(m);
        a = first_of(b, n, eu, ep);
        nb = {b[31:2], 2'b00};
        if (wb) nb = eu ? nb + 32'(4 * n) : nb - 32'(4 * n);
        @(negedge clk);
        reglist_i = m; base_i = b; up_i = up; pre_i = pre; wb_i = wb;
        load_i = ld; stack_i = stk; full_i = full; desc_i = desc; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        k = 0; p = 0; seen_done = 0;
        for (int cyc = 0; cyc < 40 && !seen_done; cyc++) begin
            if (done_o) begin
                seen_done = 1;
                chk(beat_vld_o == 1'b0, "R7 no beat with done", beat_vld_o, 0);
                chk(cyc == n, "R6/R7 done timing", cyc, n);
                chk(k == n, "R2 beat count", k, n);
                chk(new_base_o == nb, "R4 new base", new_base_o, nb);
                if (end_restart) begin
                    reglist_i = 16'h00F0; start_i = 1'b1;
                end
                @(negedge clk);
                start_i = 1'b0;
                chk(done_o == 1'b0, "R7 done one cycle", done_o, 0);
                if (end_restart)
                    chk(beat_vld_o == 1'b0, "R8 start on done ignored", beat_vld_o, 0);
            end else begin
                chk(beat_vld_o == 1'b1, "R2 beat every cycle", beat_vld_o, 1);
                while (p < 16 && !m[p]) p++;
                chk(beat_reg_o == 4'(p), "R2 register order", beat_reg_o, p);
                chk(beat_addr_o == a + 32'(4 * k), "R1 beat address", beat_addr_o, a + 32'(4 * k));
                chk(beat_addr_o[1:0] == 2'b00, "R3 alignment", beat_addr_o[1:0], 0);
                chk(beat_load_o == ld, "R10 direction", beat_load_o, ld);
                p++; k++;
                if (mid_restart && k == 1) begin
                    reglist_i = ~m; base_i = b ^ 32'h0000_1000; start_i = 1'b1;
                end else begin
                    start_i = 1'b0;
                end
                @(negedge clk);
            end
        end
        start_i = 1'b0;
        chk(seen_done, "R7 done seen", seen_done, 1);
    endtask

    initial begin
        #800000;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        chk(beat_vld_o == 1'b0, "R9 reset beat", beat_vld_o, 0);
        chk(done_o == 1'b0, "R9 reset done", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(beat_vld_o == 1'b0 && done_o == 1'b0, "R9 idle after reset", {beat_vld_o, done_o}, 0);
        // R1 all direct modes with a full mask
        for (int md = 0; md < 4; md++)
            run_op(16'hFFFF, 32'h0001_0000, md[1], md[0], 1, 0, 0, 0, 0, 0, 0);
        // R6 empty mask
        run_op(16'h0000, 32'h0000_2000, 1, 0, 1, 1, 0, 0, 0, 0, 0);
        // R3 unaligned base, R4 no writeback
        run_op(16'h8001, 32'h0000_3003, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        run_op(16'h0400, 32'h0000_4001, 1, 1, 1, 1, 0, 0, 0, 0, 0);
        // R5 all stack kinds, both directions, with misleading up/pre
        for (int sk = 0; sk < 8; sk++)
            run_op(16'h5A0C, 32'h0000_8000, !sk[0], !sk[1], 1, sk[2], 1, sk[1], sk[0], 0, 0);
        // R8 restart attempts
        run_op(16'h0F0F, 32'h0000_9000, 0, 0, 1, 1, 0, 0, 0, 1, 1);
        run_op(16'h0003, 32'h0000_A000, 1, 1, 1, 0, 0, 0, 0, 1, 1);
        // random mix
        for (int it = 0; it < 60; it++) begin
            logic [31:0] r;
            r = $urandom;
            run_op(16'($urandom), $urandom, r[0], r[1], r[2], r[3], r[4], r[5], r[6], r[7], r[8]);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule